// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the page-write controller of a parallel non-volatile memory. It watches each byte-load event, made of an address and a data byte, and looks for fixed command patterns. It keeps a persistent protect flag. For every load window it tells the controller whether the bytes loaded in that window may be committed to the array, and it marks each byte that belongs to a command so that the byte is not stored.

A three-byte pattern has two roles. It arms protection, and it also unlocks the window in which it appears. A six-byte pattern disarms protection. A change to the protect flag takes effect only when the controller reports that the programming period has ended. When protection is on and a window carries no unlock pattern, the controller still runs its timer and busy period, but the commit enable stays low. Byte-load timing and the storage array belong to the surrounding logic.

Top module: `wp_seq_detect`

## Requirements
- R1: After reset, `protect_on` is 0, `commit_ok` is 1 and `cmd_byte` is 0.
- R2: The bytes of the arm/unlock pattern (0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555) each raise `cmd_byte` during their load cycle.
- R3: After the arm pattern, `protect_on` stays 0 through `win_close` and becomes 1 only in the cycle after `prog_done`, even if the window carries no data byte.
- R4: With protection on, a window that starts with the arm/unlock pattern holds `commit_ok` at 1 until `prog_done`, and protection stays on afterwards.
- R5: With protection on, a window without the pattern holds `commit_ok` at 0 for its loads and through its busy period, and `protect_on` stays 1.
- R6: The six-byte disarm pattern (0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555) raises `cmd_byte` on each byte. Data loaded after it in the same window is committed (`commit_ok`=1), and `protect_on` falls only after `prog_done`.
- R7: A load that does not match the expected next step returns the matcher to its start state and has `cmd_byte`=0. A later byte that would have been the correct continuation is then also data.
- R8: Once a pattern has completed in a window, further loads in that window are data (`cmd_byte`=0), even if they look like pattern bytes.
- R9: `win_close` returns the matcher to its start state, so a pattern cannot be spread over two windows.
- R10: Only address bits 14:0 take part in the comparison; the bits above them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_vld | input | 1 | One byte-load event this cycle |
| ld_addr | input | ADDR_W | Address of the byte being loaded |
| ld_data | input | 8 | Data byte being loaded |
| win_close | input | 1 | Load window ended; programming period begins |
| prog_done | input | 1 | Programming period ended |
| cmd_byte | output | 1 | Current load is a command byte; do not store it |
| commit_ok | output | 1 | Bytes of the current window may be committed |
| protect_on | output | 1 | Persistent protect flag |

## Verification
The bench builds the block with the default ADDR_W of 17. This leaves two address bits above the compared field, so loads can set those bits while the compared bits 14:0 still match a pattern. Under that setting the bench drives patterns in every protect state, aborts patterns part-way, splits a pattern across two windows, and repeats pattern bytes after a pattern has completed.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
  localparam int CMP_W  = 15;
  localparam int BYTE_W = 8;

  localparam logic [CMP_W-1:0]  ADR_PRI = 15'h5555;
  localparam logic [CMP_W-1:0]  ADR_SEC = 15'h2AAA;
  localparam logic [BYTE_W-1:0] K_LEAD  = 8'hAA;
  localparam logic [BYTE_W-1:0] K_SECND = 8'h55;
  localparam logic [BYTE_W-1:0] K_ARM   = 8'hA0;
  localparam logic [BYTE_W-1:0] K_DSPFX = 8'h80;
  localparam logic [BYTE_W-1:0] K_DSEND = 8'h20;

  typedef enum logic [2:0] {
    M_IDLE,
    M_GOT1,
    M_GOT2,
    M_DIS3,
    M_DIS4,
    M_DIS5,
    M_DONE
  } mstate_t;
endpackage

// File: rtl/wp_seq_matcher.sv
module wp_seq_matcher
  import wp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_vld,
  input  logic [CMP_W-1:0]  ld_addr,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              win_close,
  output logic              cmd_hit,
  output logic              arm_hit,
  output logic              disarm_hit
);
  mstate_t st_q, st_d;
  logic    st_en;
  logic    m_lead, m_secnd, m_arm, m_dspfx, m_dsend;

  assign m_lead  = (ld_addr == ADR_PRI) && (ld_data == K_LEAD);
  assign m_secnd = (ld_addr == ADR_SEC) && (ld_data == K_SECND);
  assign m_arm   = (ld_addr == ADR_PRI) && (ld_data == K_ARM);
  assign m_dspfx = (ld_addr == ADR_PRI) && (ld_data == K_DSPFX);
  assign m_dsend = (ld_addr == ADR_PRI) && (ld_data == K_DSEND);

  assign st_en = win_close | ld_vld;

  always_comb begin
    st_d       = st_q;
    cmd_hit    = 1'b0;
    arm_hit    = 1'b0;
    disarm_hit = 1'b0;
    if (win_close) begin
      st_d = M_IDLE;
    end else if (ld_vld) begin
      case (st_q)
        M_IDLE: begin
          if (m_lead) begin st_d = M_GOT1; cmd_hit = 1'b1; end
        end
        M_GOT1: begin
          if (m_secnd) begin st_d = M_GOT2; cmd_hit = 1'b1; end
          else st_d = M_IDLE;
        end
        M_GOT2: begin
          if (m_arm) begin
            st_d = M_DONE; cmd_hit = 1'b1; arm_hit = 1'b1;
          end else if (m_dspfx) begin
            st_d = M_DIS3; cmd_hit = 1'b1;
          end else st_d = M_IDLE;
        end
        M_DIS3: begin
          if (m_lead) begin st_d = M_DIS4; cmd_hit = 1'b1; end
          else st_d = M_IDLE;
        end
        M_DIS4: begin
          if (m_secnd) begin st_d = M_DIS5; cmd_hit = 1'b1; end
          else st_d = M_IDLE;
        end
        M_DIS5: begin
          if (m_dsend) begin
            st_d = M_DONE; cmd_hit = 1'b1; disarm_hit = 1'b1;
          end else st_d = M_IDLE;
        end
        default: st_d = M_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= M_IDLE;
    else if (st_en) st_q <= st_d;
  end

  // R9: a closed window leaves the matcher at its start state
  a_r9_close_resets: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> (st_q == M_IDLE));

  // R8: a completed pattern parks the matcher until the window closes
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == M_DONE) && !win_close) |=> (st_q == M_DONE));
endmodule

// File: rtl/wp_protect_state.sv
module wp_protect_state (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_hit,
  input  logic disarm_hit,
  input  logic prog_done,
  output logic prot,
  output logic commit_ok
);
  logic prot_q, prot_d, prot_en;
  logic arm_pend_q, arm_pend_d, arm_pend_en;
  logic dis_pend_q, dis_pend_d, dis_pend_en;

  assign arm_pend_en = arm_hit | prog_done;
  assign dis_pend_en = disarm_hit | prog_done;
  assign prot_en     = prog_done & (arm_pend_q | dis_pend_q);

  always_comb begin
    arm_pend_d = prog_done ? 1'b0 : 1'b1;
    dis_pend_d = prog_done ? 1'b0 : 1'b1;
    prot_d     = arm_pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q     <= 1'b0;
      arm_pend_q <= 1'b0;
      dis_pend_q <= 1'b0;
    end else begin
      if (prot_en)     prot_q     <= prot_d;
      if (arm_pend_en) arm_pend_q <= arm_pend_d;
      if (dis_pend_en) dis_pend_q <= dis_pend_d;
    end
  end

  assign prot      = prot_q;
  assign commit_ok = !prot_q || arm_pend_q || dis_pend_q;

  // R3: a pending arm turns protection on at the end of the write period
  a_r3_arm_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && arm_pend_q) |=> prot_q);

  // R6: a pending disarm turns protection off at the end of the write period
  a_r6_disarm_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && dis_pend_q) |=> !prot_q);

  // R5: the protect flag moves only at the end of a write period
  a_r5_prot_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_done |=> $stable(prot_q));
endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_vld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              win_close,
  input  logic              prog_done,
  output logic              cmd_byte,
  output logic              commit_ok,
  output logic              protect_on
);
  localparam int UPPER_W = ADDR_W - CMP_W;

  logic arm_hit, disarm_hit;

  wp_seq_matcher u_matcher (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_vld     (ld_vld),
    .ld_addr    (ld_addr[CMP_W-1:0]),
    .ld_data    (ld_data),
    .win_close  (win_close),
    .cmd_hit    (cmd_byte),
    .arm_hit    (arm_hit),
    .disarm_hit (disarm_hit)
  );

  wp_protect_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_hit    (arm_hit),
    .disarm_hit (disarm_hit),
    .prog_done  (prog_done),
    .prot       (protect_on),
    .commit_ok  (commit_ok)
  );

  // R2: each pattern completion is also a command byte, and at most one completes
  a_r2_hit_is_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_hit || disarm_hit) |-> (cmd_byte && $onehot0({arm_hit, disarm_hit})));

  // R4: an arm/unlock completion keeps the window committable until the write ends
  a_r4_unlock_commits: assert property (@(posedge clk) disable iff (!rst_n)
    arm_hit |=> commit_ok);

  // R10: the width split above the compared field is well formed
  initial a_r10_addr_width: assert (UPPER_W >= 0);
endmodule

// File: tb/wp_seq_detect_bench.sv
module wp_seq_detect_bench;
  localparam int ADDR_W = 17;

  logic              clk;
  logic              rst_n;
  logic              ld_vld;
  logic [ADDR_W-1:0] ld_addr;
  logic [7:0]        ld_data;
  logic              win_close;
  logic              prog_done;
  logic              cmd_byte, commit_ok, protect_on;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  wp_seq_detect #(.ADDR_W(ADDR_W)) u_wp_seq_detect (
    .clk(clk), .rst_n(rst_n), .ld_vld(ld_vld), .ld_addr(ld_addr),
    .ld_data(ld_data), .win_close(win_close), .prog_done(prog_done),
    .cmd_byte(cmd_byte), .commit_ok(commit_ok), .protect_on(protect_on)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic ld(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                    input logic exp_cmd, input string what);
    @(negedge clk);
    ld_vld = 1'b1; ld_addr = a; ld_data = d;
    #2 chk(cmd_byte, exp_cmd, what);
  endtask

  task automatic settle();
    @(negedge clk);
    ld_vld = 1'b0; win_close = 1'b0; prog_done = 1'b0;
    #2;
  endtask

  task automatic close_win();
    @(negedge clk);
    ld_vld = 1'b0; win_close = 1'b1;
    settle();
  endtask

  task automatic end_prog();
    @(negedge clk);
    prog_done = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    chk(protect_on, 1'b0, "R1 protect after reset");
    chk(commit_ok, 1'b1, "R1 commit after reset");
    chk(cmd_byte, 1'b0, "R1 cmd after reset");
  endtask

  task automatic t_arm();
    ld(17'h05555, 8'hAA, 1'b1, "R2 arm byte 1");
    ld(17'h02AAA, 8'h55, 1'b1, "R2 arm byte 2");
    ld(17'h05555, 8'hA0, 1'b1, "R2 arm byte 3");
    settle();
    chk(protect_on, 1'b0, "R3 not yet protected in window");
    close_win();
    chk(protect_on, 1'b0, "R3 not yet protected while busy");
    end_prog();
    chk(protect_on, 1'b1, "R3 protected after write period");
  endtask

  task automatic t_blocked();
    ld(17'h00100, 8'h12, 1'b0, "R5 plain byte is data");
    settle();
    chk(commit_ok, 1'b0, "R5 commit blocked in window");
    close_win();
    chk(commit_ok, 1'b0, "R5 commit blocked while busy");
    end_prog();
    chk(protect_on, 1'b1, "R5 protection kept");
  endtask

  task automatic t_unlock();
    ld(17'h15555, 8'hAA, 1'b1, "R10 upper bits ignored byte 1");
    ld(17'h0AAAA, 8'h55, 1'b1, "R10 upper bits ignored byte 2");
    ld(17'h05555, 8'hA0, 1'b1, "R4 unlock byte 3");
    ld(17'h05555, 8'hAA, 1'b0, "R8 byte after pattern is data");
    ld(17'h02AAA, 8'h55, 1'b0, "R8 second byte after pattern is data");
    settle();
    chk(commit_ok, 1'b1, "R4 unlocked window commits");
    close_win();
    chk(commit_ok, 1'b1, "R4 commit held while busy");
    end_prog();
    chk(protect_on, 1'b1, "R4 protection stays on");
    chk(commit_ok, 1'b0, "R4 unlock lasts one window");
  endtask

  task automatic t_mismatch();
    ld(17'h05555, 8'hAA, 1'b1, "R7 first step matches");
    ld(17'h00000, 8'h12, 1'b0, "R7 mismatch is data");
    ld(17'h02AAA, 8'h55, 1'b0, "R7 stale continuation is data");
    ld(17'h05555, 8'hA0, 1'b0, "R7 stale final is data");
    settle();
    chk(commit_ok, 1'b0, "R7 no unlock after mismatch");
    close_win();
    end_prog();
  endtask

  task automatic t_split();
    ld(17'h05555, 8'hAA, 1'b1, "R9 first window byte 1");
    ld(17'h02AAA, 8'h55, 1'b1, "R9 first window byte 2");
    close_win();
    end_prog();
    ld(17'h05555, 8'hA0, 1'b0, "R9 next window does not continue");
    settle();
    chk(commit_ok, 1'b0, "R9 no unlock across windows");
    close_win();
    end_prog();
    chk(protect_on, 1'b1, "R9 protection kept");
  endtask

  task automatic t_disarm();
    ld(17'h05555, 8'hAA, 1'b1, "R6 disarm byte 1");
    ld(17'h02AAA, 8'h55, 1'b1, "R6 disarm byte 2");
    ld(17'h05555, 8'h80, 1'b1, "R6 disarm byte 3");
    ld(17'h05555, 8'hAA, 1'b1, "R6 disarm byte 4");
    ld(17'h02AAA, 8'h55, 1'b1, "R6 disarm byte 5");
    ld(17'h05555, 8'h20, 1'b1, "R6 disarm byte 6");
    ld(17'h00040, 8'h33, 1'b0, "R6 trailing byte is data");
    settle();
    chk(commit_ok, 1'b1, "R6 trailing data commits");
    chk(protect_on, 1'b1, "R6 still protected in window");
    close_win();
    chk(protect_on, 1'b1, "R6 still protected while busy");
    end_prog();
    chk(protect_on, 1'b0, "R6 unprotected after write period");
    chk(commit_ok, 1'b1, "R6 commit open after disarm");
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_vld = 1'b0; ld_addr = '0; ld_data = '0;
    win_close = 1'b0; prog_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_arm();
    t_blocked();
    t_unlock();
    t_mismatch();
    t_split();
    t_disarm();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule